// File: doc/BRIEF.md
# Bus Identifier Enumerator

This controller sits on the master side of a single-wire, open-drain bus and discovers the 64-bit identifiers of every attached slave, one identifier per pass. It does not time the wire itself. Instead it drives a bit-level physical layer through a request/acknowledge handshake. It asks for a bus reset and reads the presence answer. It then writes the search command byte and, for each identifier bit, reads the bit, reads its complement and writes back the chosen branch.

Several slaves answer at once on a wired-AND line, so a pair of zeros means the participating slaves disagree at that position. The engine keeps the deepest position where it last took the zero branch. On the next pass it follows the previous identifier up to that point, turns to the one branch there, and explores zeros beyond it. Repeating `start` therefore lists every device. A mode input restricts the search to slaves holding an unacknowledged interrupt by sending a different command byte.

Top module: `owsearch_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `phy_req`, `id_valid`, `search_done`, `no_device` and `no_participant` are all 0.
- R2: If the reset operation is acknowledged with `phy_presence` = 0, `no_device` is set, the engine returns to idle, and no write or read is requested in that pass.
- R3: With `alarm_mode` = 0 at `start`, the first eight writes after the reset carry command 0xF0, least significant bit first.
- R4: With `alarm_mode` = 1 at `start`, the command written is 0xEC. The per-bit procedure is unchanged.
- R5: Operations are coded on `phy_op` as 0 = bus reset, 1 = write bit, 2 = read bit. Each identifier bit uses exactly read, read, write, in that order. A request stays asserted with `phy_op` and `phy_wbit` unchanged until `phy_ack`.
- R6: Identifier bit positions are numbered 1 to 64. If the two reads differ, the engine writes the first read value. On a 0/0 pair below the stored last-branch position, it repeats the previous identifier's bit. At that position it writes 1. Above it, it writes 0. Every 0/0 pair resolved with 0 becomes the newest zero-branch position.
- R7: Bits are gathered least significant bit first. `id_out` is presented with `id_valid` high for exactly one cycle, in the cycle after the acknowledge of the 64th write.
- R8: Successive passes return each participating device exactly once, in ascending order of the bit-reversed identifier. `search_done` rises together with `id_valid` of the final pass and is clear on earlier passes. The next `start` begins a fresh enumeration.
- R9: A 1/1 read pair aborts the pass with `no_participant` set and no `id_valid`. The stored branch state is cleared, so the next `start` enumerates from the beginning.
- R10: `start` asserted while `busy` is high is ignored: no extra bus reset is issued and the running pass completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one search pass when idle |
| alarm_mode | input | 1 | 1 selects the interrupt-only search command |
| phy_req | output | 1 | Operation request to the bit layer |
| phy_op | output | 2 | 0 reset, 1 write, 2 read |
| phy_wbit | output | 1 | Bit to write |
| phy_ack | input | 1 | One-cycle operation complete |
| phy_rbit | input | 1 | Read result, valid with `phy_ack` |
| phy_presence | input | 1 | Presence result, valid with `phy_ack` of a reset |
| id_out | output | 64 | Identifier found by the last pass |
| id_valid | output | 1 | One-cycle strobe for `id_out` |
| busy | output | 1 | Pass in progress |
| search_done | output | 1 | Last device of the enumeration has been returned |
| no_device | output | 1 | Last pass saw no presence |
| no_participant | output | 1 | Last pass aborted on a 1/1 read pair |

## Verification
Every result is registered off a `phy_ack` edge. `no_device` is due the cycle after the reset acknowledge, and `no_participant` the cycle after the second read acknowledge. `id_valid` and `search_done` are due the cycle after the 64th write acknowledge. `busy` falls in that same cycle. The bench drives the bit layer and samples on falling clock edges. A pass's results are therefore read in the first falling edge after the acknowledging rising edge, and the strobe is checked low again one falling edge later. The bench's own bus model applies wired-AND reads and drops out devices on each write. It checks the operation order and command byte at every acknowledge, and compares identifiers against a bit-reversed sort of the participating devices.

// File: rtl/owsearch_engine.sv
module owsearch_engine #(
  parameter int ID_BITS = 64,
  parameter logic [7:0] CMD_ALL = 8'hF0,
  parameter logic [7:0] CMD_ALARM = 8'hEC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               alarm_mode,
  output logic               phy_req,
  output logic [1:0]         phy_op,
  output logic               phy_wbit,
  input  logic               phy_ack,
  input  logic               phy_rbit,
  input  logic               phy_presence,
  output logic [ID_BITS-1:0] id_out,
  output logic               id_valid,
  output logic               busy,
  output logic               search_done,
  output logic               no_device,
  output logic               no_participant
);
  localparam int PW = $clog2(ID_BITS + 1);
  localparam logic [1:0] OP_RESET = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_CMD, S_RA, S_RB, S_WR} st_t;

  st_t st;
  logic [7:0] cmd;
  logic [2:0] cbit;
  logic [PW-1:0] idx, last_disc, zero_br;
  logic a_bit, dir, pick;
  logic [ID_BITS-1:0] id;
  wire [PW-1:0] pos = idx + PW'(1);

  always_comb begin
    if (a_bit != phy_rbit)    pick = a_bit;
    else if (pos < last_disc) pick = id[0];
    else                      pick = (pos == last_disc);
  end

  assign busy     = (st != S_IDLE);
  assign phy_req  = busy;
  assign phy_op   = (st == S_RST) ? OP_RESET :
                    (st == S_CMD || st == S_WR) ? OP_WRITE : OP_READ;
  assign phy_wbit = (st == S_CMD) ? cmd[cbit] : dir;
  assign id_out   = id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cmd <= '0;
      cbit <= '0;
      idx <= '0;
      last_disc <= '0;
      zero_br <= '0;
      a_bit <= 1'b0;
      dir <= 1'b0;
      id <= '0;
      id_valid <= 1'b0;
      search_done <= 1'b0;
      no_device <= 1'b0;
      no_participant <= 1'b0;
    end else begin
      id_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cmd <= alarm_mode ? CMD_ALARM : CMD_ALL;
          cbit <= '0;
          idx <= '0;
          zero_br <= '0;
          search_done <= 1'b0;
          no_device <= 1'b0;
          no_participant <= 1'b0;
          st <= S_RST;
        end
        S_RST: if (phy_ack) begin
          if (phy_presence) st <= S_CMD;
          else begin
            no_device <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_CMD: if (phy_ack) begin
          cbit <= cbit + 3'd1;
          if (cbit == 3'd7) st <= S_RA;
        end
        S_RA: if (phy_ack) begin
          a_bit <= phy_rbit;
          st <= S_RB;
        end
        S_RB: if (phy_ack) begin
          if (a_bit && phy_rbit) begin
            no_participant <= 1'b1;
            last_disc <= '0;
            st <= S_IDLE;
          end else begin
            dir <= pick;
            if (!a_bit && !phy_rbit && !pick) zero_br <= pos;
            st <= S_WR;
          end
        end
        S_WR: if (phy_ack) begin
          id <= {dir, id[ID_BITS-1:1]};
          if (idx == PW'(ID_BITS - 1)) begin
            id_valid <= 1'b1;
            last_disc <= zero_br;
            search_done <= (zero_br == '0);
            st <= S_IDLE;
          end else begin
            idx <= pos;
            st <= S_RA;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owsearch_engine_chk.sv
module owsearch_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phy_req,
  input logic [1:0] phy_op,
  input logic       phy_wbit,
  input logic       phy_ack,
  input logic       id_valid,
  input logic       busy,
  input logic       search_done,
  input logic       no_device,
  input logic       no_participant
);
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && !phy_ack |=> phy_req && $stable(phy_op) && $stable(phy_wbit));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !phy_req);

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);

  a_r8_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(search_done) |-> id_valid);

  a_r2_nodev_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_device) |-> !busy && !id_valid && $past(phy_op) == 2'd0);

  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_participant) |-> !busy && !id_valid && $past(phy_op) == 2'd2);
endmodule

bind owsearch_engine owsearch_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phy_req(phy_req), .phy_op(phy_op),
  .phy_wbit(phy_wbit), .phy_ack(phy_ack), .id_valid(id_valid), .busy(busy),
  .search_done(search_done), .no_device(no_device),
  .no_participant(no_participant)
);

// File: tb/owsearch_engine_test.sv
module owsearch_engine_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, alarm_mode = 1'b0;
  logic phy_ack = 1'b0, phy_rbit = 1'b0, phy_presence = 1'b0;
  logic phy_req, phy_wbit, id_valid, busy, search_done, no_device, no_participant;
  logic [1:0] phy_op;
  logic [63:0] id_out;

  owsearch_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .alarm_mode(alarm_mode),
    .phy_req(phy_req), .phy_op(phy_op), .phy_wbit(phy_wbit), .phy_ack(phy_ack),
    .phy_rbit(phy_rbit), .phy_presence(phy_presence), .id_out(id_out),
    .id_valid(id_valid), .busy(busy), .search_done(search_done),
    .no_device(no_device), .no_participant(no_participant)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus model
  logic [63:0] dev_id[4];
  bit dev_al[4];
  bit act[4];
  int ndev = 0, fault_bit = -1;
  int stage = 0, cmd_cnt = 0, sbit = 0, rphase = 0, cnt = 0;
  int resets = 0, ops_after_reset = 0;
  logic [7:0] cmd_seen, exp_cmd = 8'hF0;

  task automatic serve();
    logic v;
    case (phy_op)
      2'd0: begin
        resets++;
        ops_after_reset = 0;
        phy_presence = (ndev > 0);
        for (int i = 0; i < 4; i++) act[i] = (i < ndev);
        stage = 1; cmd_cnt = 0; sbit = 0; rphase = 0;
      end
      2'd1: begin
        ops_after_reset++;
        if (stage == 1) begin
          cmd_seen[cmd_cnt] = phy_wbit;
          cmd_cnt++;
          if (cmd_cnt == 8) begin
            stage = 2;
            chk(cmd_seen == exp_cmd, exp_cmd == 8'hEC ? "R4" : "R3", 64'(cmd_seen), 64'(exp_cmd));
            if (cmd_seen == 8'hEC)
              for (int i = 0; i < 4; i++) if (!dev_al[i]) act[i] = 0;
          end
        end else begin
          chk(stage == 2 && rphase == 2, "R5 write order", 64'(rphase), 64'd2);
          for (int i = 0; i < 4; i++)
            if (act[i] && dev_id[i][sbit] != phy_wbit) act[i] = 0;
          sbit++;
          rphase = 0;
        end
      end
      default: begin
        ops_after_reset++;
        chk(stage == 2 && rphase < 2 && phy_op == 2'd2, "R5 read order", 64'(rphase), 64'd0);
        v = 1'b1;
        for (int i = 0; i < 4; i++)
          if (act[i] && sbit < 64) v = v & (rphase == 1 ? ~dev_id[i][sbit] : dev_id[i][sbit]);
        if (sbit == fault_bit) v = 1'b1;
        phy_rbit = v;
        rphase++;
      end
    endcase
  endtask

  initial forever begin
    @(negedge clk);
    phy_ack = 1'b0;
    if (!rst_n) cnt = 0;
    else if (phy_req) begin
      if (cnt == 2) begin
        cnt = 0;
        phy_ack = 1'b1;
        serve();
      end else cnt++;
    end else cnt = 0;
  end

  function automatic logic [63:0] brev(input logic [63:0] v);
    for (int i = 0; i < 64; i++) brev[i] = v[63-i];
  endfunction

  task automatic run_pass(input int poke_at, output logic [63:0] got, output bit gotv, output bit dv);
    bit pv = 0;
    got = '0; gotv = 0; dv = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (pv) chk(!id_valid, "R7 strobe width", 64'(id_valid), 64'd0);
      pv = 0;
      start = (c == poke_at);
      if (id_valid) begin
        got = id_out; gotv = 1; dv = search_done; pv = 1;
      end
      if (!busy) break;
    end
    start = 1'b0;
    @(negedge clk);
    if (pv) chk(!id_valid, "R7 strobe width", 64'(id_valid), 64'd0);
  endtask

  task automatic enumerate(input bit mode, input string tag);
    logic [63:0] e[4];
    logic [63:0] t, got;
    bit gv, dv;
    int m = 0;
    for (int i = 0; i < ndev; i++)
      if (!mode || dev_al[i]) begin e[m] = dev_id[i]; m++; end
    for (int i = 0; i < m; i++)
      for (int j = 0; j + 1 < m - i; j++)
        if (brev(e[j]) > brev(e[j+1])) begin t = e[j]; e[j] = e[j+1]; e[j+1] = t; end
    alarm_mode = mode;
    exp_cmd = mode ? 8'hEC : 8'hF0;
    for (int p = 0; p < m; p++) begin
      run_pass(-1, got, gv, dv);
      chk(gv, "R7 valid seen", 64'(gv), 64'd1);
      chk(got == e[p], tag, got, e[p]);
      chk(dv == (p == m - 1), "R8 done timing", 64'(dv), 64'(p == m - 1));
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] got;
    bit gv, dv;
    int r0, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, phy_req, id_valid, search_done, no_device, no_participant} == 6'b0,
        "R1 reset state", 64'({busy, phy_req, id_valid, search_done, no_device, no_participant}), 64'd0);

    // single device
    dev_id[0] = 64'h1234_5678_9ABC_DEF0; dev_al[0] = 1;
    ndev = 1;
    enumerate(0, "R6 single id");

    // four devices, branches at first and last bit
    dev_id[0] = 64'h0;                   dev_al[0] = 0;
    dev_id[1] = 64'h8000_0000_0000_0000; dev_al[1] = 1;
    dev_id[2] = 64'h1;                   dev_al[2] = 0;
    dev_id[3] = 64'hA5A5_0F0F_3C3C_9669; dev_al[3] = 1;
    ndev = 4;
    enumerate(0, "R8 order");

    // restart after done
    run_pass(-1, got, gv, dv);
    chk(got == 64'h0 && gv, "R8 restart", got, 64'h0);
    chk(!dv, "R8 done clear", 64'(dv), 64'd0);

    // interrupt-only search
    enumerate(1, "R4 alarm ids");

    // start while busy
    ndev = 1; dev_id[0] = 64'hFEDC_BA98_7654_3210;
    alarm_mode = 0; exp_cmd = 8'hF0;
    r0 = resets;
    run_pass(100, got, gv, dv);
    chk(resets == r0 + 1, "R10 single reset", 64'(resets - r0), 64'd1);
    chk(got == 64'hFEDC_BA98_7654_3210 && gv, "R10 id", got, 64'hFEDC_BA98_7654_3210);

    // no device
    ndev = 0;
    run_pass(-1, got, gv, dv);
    chk(no_device && !busy, "R2 flag", 64'({no_device, busy}), 64'b10);
    chk(ops_after_reset == 0, "R2 no ops", 64'(ops_after_reset), 64'd0);
    chk(!gv, "R2 no strobe", 64'(gv), 64'd0);

    // no participant fault, then fresh enumeration
    ndev = 2;
    dev_id[0] = 64'h0000_0000_0000_00F0;
    dev_id[1] = 64'h0000_0000_0000_0010;
    fault_bit = 5;
    run_pass(-1, got, gv, dv);
    chk(no_participant && !gv, "R9 abort", 64'({no_participant, gv}), 64'b10);
    fault_bit = -1;
    enumerate(0, "R9 fresh after abort");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule